// File: doc/BRIEF.md
# 20-Bit Extended ALU with Stepped Shifts

This unit is the arithmetic and shift datapath of a 16-bit processor whose registers have been widened to 20 bits. It adds, subtracts, compares, sign-extends a byte, and performs single-bit right rotates, right arithmetic shifts and left shifts at byte, word or 20-bit address size. For each operation it produces a result, the N, Z, C and V flags, and a write strobe for the destination register.

An operation is requested with a one-cycle `start` pulse while the unit is idle. All operands are captured on that edge. This means a source and destination naming the same register still produce flags from the original source value. Arithmetic finishes on the next edge. A shift repeats one bit per cycle for one to four steps, and the carry from each step feeds the next. `done` pulses on the completing edge, and the result and flags then hold until the next operation completes.

Top module: `xalu20`

## Requirements
- R1: While reset is low and after its release, `result`, all four flags, `busy`, `done` and `wr_en` are 0.
- R2: `start` is taken only while `busy` is 0. On that edge it captures `op`, `size`, `src`, `dst`, `cin` and `steps_m1`. A `start` raised while busy, and any input change after capture, have no effect on the operation in progress.
- R3: ADD (`op`=0) gives dst+src at the selected size. C is the carry out of the size's top bit. V is set when two operands of equal sign give a result of the other sign.
- R4: SUB (`op`=1) gives dst−src. C is 1 when no borrow occurs and 0 on a borrow, at every size including 20-bit. V is set when operands of differing sign give a result whose sign differs from dst. CMP (`op`=2) sets the same result and flags but keeps `wr_en` low.
- R5: `size` 0 selects byte (top bit 7), 1 selects word (top bit 15), and 2 or 3 selects 20-bit address (top bit 19). Operands are masked to the size, and the result is zero-extended to 20 bits, so word results clear bits 19..16.
- R6: N is the top bit of the selected size, and Z is 1 exactly when the sized result is zero.
- R7: SXT (`op`=3) copies dst bit 7 into bits 19..8 for every `size`. N is bit 19, C is 1 when the result is non-zero, and V is 0.
- R8: RRC (`op`=4) shifts right one bit, drops old bit 0 into C, and places the carry at the size's top bit. V is 0. At 20-bit size the shifted value has bit 19 clear before the carry is placed there.
- R9: RRU (`op`=5) behaves as RRC, but a 0 enters the top bit whatever the carry.
- R10: RRA (`op`=6) shifts right one bit and keeps the size's top bit, so word size uses bit 15. C is old bit 0 and V is 0.
- R11: RLA (`op`=7) shifts left one bit with 0 into bit 0. C is the old top bit, and V is 1 when the top bit changes.
- R12: Shift ops run `steps_m1`+1 steps, one per cycle, each using the previous step's carry. `done` and `wr_en` pulse for one cycle on the last step, `steps_m1` cycles after arithmetic would finish. Ops 0–3 ignore `steps_m1` and finish one cycle after capture.
- R13: Between completions, `result` and the flags hold their values and `wr_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an operation (honoured when idle) |
| op | input | 3 | Operation code (see R3–R11) |
| size | input | 2 | Operand size select (see R5) |
| src | input | 20 | Source operand |
| dst | input | 20 | Destination operand, also the shift operand |
| cin | input | 1 | Incoming carry flag |
| steps_m1 | input | 2 | Shift step count minus one |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Destination write strobe |
| result | output | 20 | Zero-extended result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
The bench targets the corners where a narrow or inverted flag rule shows up:
- A 20-bit subtract across zero catches a design that reports carry as borrow, because it shows C set where 0 is expected.
- A word add on a destination with dirty upper bits catches a design that leaves bits 19..16 set.
- A byte sign extension catches a design that stops at bit 15.
- A 20-bit rotate of all ones with a clear carry catches a mask that lets a stray high bit survive.
- A word arithmetic shift of a value whose bit 19 is set catches a design that takes bit 19 as the sign.
- Multi-step shifts, and a start pulse raised while busy, expose a carry that does not chain between steps, an off-by-one step count, or a second operation that sneaks in.

// File: rtl/xalu20_pkg.sv
package xalu20_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_CMP = 3'd2,
        OP_SXT = 3'd3,
        OP_RRC = 3'd4,
        OP_RRU = 3'd5,
        OP_RRA = 3'd6,
        OP_RLA = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_ADDR = 2'd2,
        SZ_ADDR_ALT = 2'd3
    } alu_size_e;

    function automatic logic is_shift_op(alu_op_e op);
        return (op == OP_RRC) || (op == OP_RRU) || (op == OP_RRA) || (op == OP_RLA);
    endfunction

endpackage

// File: rtl/xalu20_size_dec.sv
module xalu20_size_dec
    import xalu20_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int IDX_W  = 5
) (
    input  alu_size_e         size,
    output logic [DATA_W-1:0] mask,
    output logic [IDX_W-1:0]  top
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    always_comb begin
        case (size)
            SZ_BYTE: top = IDX_W'(BYTE_W - 1);
            SZ_WORD: top = IDX_W'(WORD_W - 1);
            default: top = IDX_W'(DATA_W - 1);
        endcase
        mask = ALL_ONES >> (IDX_W'(DATA_W - 1) - top);
    end
endmodule

// File: rtl/xalu20_arith.sv
module xalu20_arith
    import xalu20_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int IDX_W  = 5
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] mask,
    input  logic [IDX_W-1:0]  top,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              c,
    output logic              v
);
    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] s_m;
    logic [DATA_W-1:0] d_m;
    logic [DATA_W-1:0] s_inv;
    logic [IDX_W-1:0]  carry_pos;

    always_comb begin
        s_m       = src & mask;
        d_m       = dst & mask;
        s_inv     = ~s_m & mask;
        carry_pos = top + IDX_W'(1);
        wide      = '0;
        res       = '0;
        c         = 1'b0;
        v         = 1'b0;
        case (op)
            OP_ADD: begin
                wide = {1'b0, d_m} + {1'b0, s_m};
                res  = wide[DATA_W-1:0] & mask;
                c    = wide[carry_pos];
                v    = (d_m[top] == s_m[top]) && (res[top] != d_m[top]);
            end
            OP_SUB, OP_CMP: begin
                // two's complement subtract: carry out high means no borrow
                wide = {1'b0, d_m} + {1'b0, s_inv} + (DATA_W+1)'(1);
                res  = wide[DATA_W-1:0] & mask;
                c    = wide[carry_pos];
                v    = (d_m[top] != s_m[top]) && (res[top] != d_m[top]);
            end
            OP_SXT: begin
                res = {{(DATA_W-BYTE_W){dst[BYTE_W-1]}}, dst[BYTE_W-1:0]};
                c   = |res;
            end
            default: ;
        endcase
        n = (op == OP_SXT) ? res[DATA_W-1] : res[top];
        z = ~|res;
    end
endmodule

// File: rtl/xalu20_shift.sv
module xalu20_shift
    import xalu20_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int IDX_W  = 5
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] val,
    input  logic              cin,
    input  logic [DATA_W-1:0] mask,
    input  logic [IDX_W-1:0]  top,
    output logic [DATA_W-1:0] res,
    output logic              n,
    output logic              z,
    output logic              c,
    output logic              v
);
    logic [DATA_W-1:0] vm;
    logic [DATA_W-1:0] half;

    always_comb begin
        vm   = val & mask;
        half = vm >> 1;            // top bit of the size is now clear
        res  = half;
        c    = vm[0];
        v    = 1'b0;
        case (op)
            OP_RRC: res = half | (DATA_W'(cin) << top);
            OP_RRU: res = half;
            OP_RRA: res = half | (DATA_W'(vm[top]) << top);
            OP_RLA: begin
                res = (vm << 1) & mask;
                c   = vm[top];
                v   = vm[top] ^ res[top];
            end
            default: ;
        endcase
        n = res[top];
        z = ~|res;
    end
endmodule

// File: rtl/xalu20.sv
module xalu20
    import xalu20_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        op,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] src,
    input  logic [DATA_W-1:0] dst,
    input  logic              cin,
    input  logic [CNT_W-1:0]  steps_m1,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    typedef struct packed {
        logic              busy;
        alu_op_e           op;
        alu_size_e         size;
        logic [DATA_W-1:0] src;
        logic [DATA_W-1:0] acc;
        logic              carry;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] res;
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic              done;
        logic              wr;
    } state_t;

    state_t q, d;

    logic [DATA_W-1:0] sz_mask;
    logic [IDX_W-1:0]  sz_top;
    logic [DATA_W-1:0] ar_res, sh_res;
    logic ar_n, ar_z, ar_c, ar_v;
    logic sh_n, sh_z, sh_c, sh_v;

    xalu20_size_dec #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_size (
        .size (q.size),
        .mask (sz_mask),
        .top  (sz_top)
    );

    xalu20_arith #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_arith (
        .op   (q.op),
        .src  (q.src),
        .dst  (q.acc),
        .mask (sz_mask),
        .top  (sz_top),
        .res  (ar_res),
        .n    (ar_n),
        .z    (ar_z),
        .c    (ar_c),
        .v    (ar_v)
    );

    xalu20_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
        .op   (q.op),
        .val  (q.acc),
        .cin  (q.carry),
        .mask (sz_mask),
        .top  (sz_top),
        .res  (sh_res),
        .n    (sh_n),
        .z    (sh_z),
        .c    (sh_c),
        .v    (sh_v)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.wr   = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy  = 1'b1;
                d.op    = alu_op_e'(op);
                d.size  = alu_size_e'(size);
                d.src   = src;
                d.acc   = dst;
                d.carry = cin;
                d.left  = is_shift_op(alu_op_e'(op)) ? steps_m1 : '0;
            end
        end else if (is_shift_op(q.op)) begin
            d.acc   = sh_res;
            d.carry = sh_c;
            if (q.left == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.wr   = 1'b1;
                d.res  = sh_res;
                d.n    = sh_n;
                d.z    = sh_z;
                d.c    = sh_c;
                d.v    = sh_v;
            end else begin
                d.left = q.left - CNT_W'(1);
            end
        end else begin
            d.busy = 1'b0;
            d.done = 1'b1;
            d.wr   = (q.op != OP_CMP);
            d.res  = ar_res;
            d.n    = ar_n;
            d.z    = ar_z;
            d.c    = ar_c;
            d.v    = ar_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = q.busy;
    assign done   = q.done;
    assign wr_en  = q.wr;
    assign result = q.res;
    assign flag_n = q.n;
    assign flag_z = q.z;
    assign flag_c = q.c;
    assign flag_v = q.v;
endmodule

// File: rtl/xalu20_chk.sv
module xalu20_chk
    import xalu20_pkg::*;
#(
    parameter int DATA_W = 20,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [2:0]        op,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] src,
    input logic [DATA_W-1:0] dst,
    input logic              cin,
    input logic [CNT_W-1:0]  steps_m1,
    input logic              busy,
    input logic              done,
    input logic              wr_en,
    input logic [DATA_W-1:0] result,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_c,
    input logic              flag_v
);
    logic [2:0] lat_op;
    logic [1:0] lat_size;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_op   <= '0;
            lat_size <= '0;
        end else if (start && !busy) begin
            lat_op   <= op;
            lat_size <= size;
        end
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> !busy);

    // R13
    write_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    // R13
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(flag_c) && $stable(flag_z)));

    // R4
    cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_op == OP_CMP) |-> !wr_en);

    // R5
    word_upper_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_op != OP_SXT && lat_size == SZ_WORD) |-> (result[DATA_W-1:WORD_W] == '0));

    // R7
    sxt_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && lat_op == OP_SXT) |->
            ((result[DATA_W-1:BYTE_W-1] == '0) || (&result[DATA_W-1:BYTE_W-1])));

    // R8
    right_shift_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (lat_op == OP_RRC || lat_op == OP_RRU || lat_op == OP_RRA)) |-> !flag_v);
endmodule

bind xalu20 xalu20_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op       (op),
    .size     (size),
    .src      (src),
    .dst      (dst),
    .cin      (cin),
    .steps_m1 (steps_m1),
    .busy     (busy),
    .done     (done),
    .wr_en    (wr_en),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v)
);

// File: tb/xalu20_test.sv
`timescale 1ns/1ps
module xalu20_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [19:0] src = '0;
    logic [19:0] dst = '0;
    logic        cin = 1'b0;
    logic [1:0]  steps_m1 = '0;
    logic        busy, done, wr_en;
    logic [19:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    xalu20 uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size(size),
        .src(src), .dst(dst), .cin(cin), .steps_m1(steps_m1),
        .busy(busy), .done(done), .wr_en(wr_en), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    // fields: op, size, src, dst, cin, steps_m1, result, NZCV, wr_en, requirement
    localparam int NV = 25;
    localparam logic [76:0] VEC [NV] = '{
        {3'd0, 2'd0, 20'h00001, 20'h0007F, 1'b0, 2'd0, 20'h00080, 4'b1001, 1'b1, 4'd3},  // R3 byte signed overflow
        {3'd0, 2'd0, 20'h000FF, 20'h00001, 1'b0, 2'd0, 20'h00000, 4'b0110, 1'b1, 4'd6},  // R6 zero with carry
        {3'd0, 2'd1, 20'h00001, 20'hAFFFF, 1'b0, 2'd0, 20'h00000, 4'b0110, 1'b1, 4'd5},  // R5 word clears upper
        {3'd0, 2'd2, 20'h00001, 20'h7FFFF, 1'b0, 2'd0, 20'h80000, 4'b1001, 1'b1, 4'd3},  // R3 20-bit overflow
        {3'd1, 2'd1, 20'h00003, 20'h00005, 1'b0, 2'd0, 20'h00002, 4'b0010, 1'b1, 4'd4},  // R4 no borrow
        {3'd1, 2'd1, 20'h00005, 20'h00003, 1'b0, 2'd0, 20'h0FFFE, 4'b1000, 1'b1, 4'd4},  // R4 borrow
        {3'd1, 2'd2, 20'h00001, 20'h00000, 1'b0, 2'd0, 20'hFFFFF, 4'b1000, 1'b1, 4'd4},  // R4 20-bit borrow
        {3'd1, 2'd2, 20'h00001, 20'h80000, 1'b0, 2'd0, 20'h7FFFF, 4'b0011, 1'b1, 4'd4},  // R4 20-bit overflow
        {3'd2, 2'd0, 20'h00042, 20'h00042, 1'b0, 2'd0, 20'h00000, 4'b0110, 1'b0, 4'd4},  // R4 compare, no write
        {3'd1, 2'd1, 20'h01234, 20'h01234, 1'b0, 2'd0, 20'h00000, 4'b0110, 1'b1, 4'd2},  // R2 same operand
        {3'd3, 2'd1, 20'h00000, 20'h00080, 1'b0, 2'd0, 20'hFFF80, 4'b1010, 1'b1, 4'd7},  // R7 negative byte
        {3'd3, 2'd0, 20'h00000, 20'h1237F, 1'b0, 2'd0, 20'h0007F, 4'b0010, 1'b1, 4'd7},  // R7 positive byte
        {3'd3, 2'd2, 20'h00000, 20'h00000, 1'b0, 2'd0, 20'h00000, 4'b0100, 1'b1, 4'd7},  // R7 zero
        {3'd4, 2'd1, 20'h00000, 20'h00001, 1'b1, 2'd0, 20'h08000, 4'b1010, 1'b1, 4'd8},  // R8 word carry in
        {3'd4, 2'd2, 20'h00000, 20'hFFFFF, 1'b0, 2'd0, 20'h7FFFF, 4'b0010, 1'b1, 4'd8},  // R8 20-bit mask
        {3'd4, 2'd2, 20'h00000, 20'h00002, 1'b1, 2'd0, 20'h80001, 4'b1000, 1'b1, 4'd8},  // R8 carry to bit 19
        {3'd5, 2'd1, 20'h00000, 20'h08001, 1'b1, 2'd0, 20'h04000, 4'b0010, 1'b1, 4'd9},  // R9 zero enters top
        {3'd6, 2'd1, 20'h00000, 20'hF8002, 1'b0, 2'd0, 20'h0C001, 4'b1000, 1'b1, 4'd10}, // R10 word sign bit 15
        {3'd6, 2'd0, 20'h00000, 20'h00081, 1'b0, 2'd0, 20'h000C0, 4'b1010, 1'b1, 4'd10}, // R10 byte
        {3'd7, 2'd1, 20'h00000, 20'h04001, 1'b0, 2'd0, 20'h08002, 4'b1001, 1'b1, 4'd11}, // R11 sign change
        {3'd7, 2'd0, 20'h00000, 20'h00080, 1'b0, 2'd0, 20'h00000, 4'b0111, 1'b1, 4'd11}, // R11 carry out, zero
        {3'd4, 2'd0, 20'h00000, 20'h00003, 1'b1, 2'd3, 20'h00070, 4'b0000, 1'b1, 4'd12}, // R12 four-step rotate
        {3'd7, 2'd2, 20'h00000, 20'h40001, 1'b0, 2'd1, 20'h00004, 4'b0011, 1'b1, 4'd12}, // R12 two-step left
        {3'd0, 2'd1, 20'h00001, 20'h00002, 1'b0, 2'd3, 20'h00003, 4'b0000, 1'b1, 4'd12}, // R12 add ignores count
        {3'd6, 2'd2, 20'h00000, 20'h80000, 1'b0, 2'd2, 20'hF0000, 4'b1000, 1'b1, 4'd10}  // R10 three-step 20-bit
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic launch(input logic [2:0] o, input logic [1:0] s, input logic [19:0] a,
                          input logic [19:0] b, input logic c, input logic [1:0] m);
        @(negedge clk);
        op = o; size = s; src = a; dst = b; cin = c; steps_m1 = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs after capture: must not matter (R2)
        op = 3'd2; size = 2'd0; src = 20'hABCDE; dst = 20'h13579; cin = ~c; steps_m1 = 2'd0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (R12)");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 result in reset", result, 0);
        chk("R1 control in reset", {busy, done, wr_en}, 0);
        chk("R1 flags in reset", {flag_n, flag_z, flag_c, flag_v}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 state after release", {busy, done, wr_en, flag_n, flag_z, flag_c, flag_v, result}, 0);

        for (int i = 0; i < NV; i++) begin
            logic [76:0] e;
            int steps;
            e = VEC[i];
            steps = (e[76:74] >= 3'd4) ? int'(e[30:29]) + 1 : 1;
            launch(e[76:74], e[73:72], e[71:52], e[51:32], e[31], e[30:29]);
            repeat (steps - 1) @(negedge clk);
            chk($sformatf("R%0d vec%0d not early", e[3:0], i), done, 1'b0);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d done", e[3:0], i), done, 1'b1);
            chk($sformatf("R%0d vec%0d result", e[3:0], i), result, e[28:9]);
            chk($sformatf("R%0d vec%0d NZCV", e[3:0], i), {flag_n, flag_z, flag_c, flag_v}, e[8:5]);
            chk($sformatf("R%0d vec%0d wr_en", e[3:0], i), wr_en, e[4]);
        end

        // R2: start while busy is ignored, operands are held
        launch(3'd4, 2'd0, 20'h0, 20'h00003, 1'b1, 2'd3);
        start = 1'b1; op = 3'd0; size = 2'd2; src = 20'h00001; dst = 20'h00001;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2 busy during shift", {busy, done}, 2'b10);
        @(negedge clk);
        chk("R2 result after ignored start", result, 20'h00070);
        chk("R12 done on final step", {done, wr_en}, 2'b11);
        @(negedge clk);
        chk("R2 no queued operation", {busy, done}, 2'b00);

        // R13: values hold while idle
        repeat (3) @(negedge clk);
        chk("R13 result held", result, 20'h00070);
        chk("R13 flags held", {flag_n, flag_z, flag_c, flag_v}, 4'b0000);
        chk("R13 no write while idle", {wr_en, done}, 2'b00);

        summary();
        $finish;
    end
endmodule